// File: doc/BRIEF.md
# Interrupt Mask and Priority Gate

This block decides, once per clock, whether a pending interrupt may be taken by the core. It has two modes. In the classic mode, eight pending lines are each gated by their own enable bit. Lines 1 and 0 are the software interrupt bits, and lines 7 to 2 are the hardware lines. In the external-controller mode, an outside interrupt controller presents a 6-bit request code. Enable bits 7 to 2 are then read as a 6-bit current priority level. A request wins only when its code is strictly above that level.

The external-controller mode is in force only when three conditions hold: the capability flag is 1, the vectored-mode bit is 1, and the vector spacing field is non-zero. If any of these is missing, the classic mode applies. Enable bits 1 and 0 gate the two software bits in both modes. Three conditions veto every request: the exception-level bit, the error-level bit, and a cleared global enable. The combined decision is registered, so `irq_req` follows its inputs one clock later. Vector address generation lies outside this block.

Top module: `irq_gate_top`

## Requirements
- R1: While `rst` is 1 at a rising clock edge, `irq_req` is 0 after that edge, whatever the other inputs are.
- R2: In the classic mode, `irq_req` is raised if, for some i in 0..7, line i of `{hw_pend, sw_pend}` and `irq_mask[i]` are both 1. Here `hw_pend[k]` is line k+2 and `sw_pend[k]` is line k.
- R3: The external-controller mode is selected only when `eic_cap`, `vec_mode` and a non-zero `vec_space` all hold. If any one is missing, the classic rule of R2 applies.
- R4: In the external-controller mode, the presented `eic_level` is accepted only when it is numerically greater than `irq_mask[7:2]`. A level equal to the current level, or below it, is rejected.
- R5: A presented `eic_level` of 0 is never accepted, even when the current level is 0.
- R6: `irq_mask[1:0]` gates `sw_pend[1:0]` bit by bit in both modes. In the external-controller mode, an enabled and pending software bit raises a request whatever the priority level is.
- R7: In the external-controller mode, `hw_pend` has no effect on `irq_req`.
- R8: When `exl` or `erl` is 1, no request is raised.
- R9: When `glob_ie` is 0, no request is raised.
- R10: `irq_req` is registered. It shows the decision for the inputs held before a rising edge, starting at that edge, and it falls in the same way.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_mask | input | 8 | Enable bits. In the external-controller mode, bits 7..2 hold the current level. |
| hw_pend | input | 6 | Pending hardware lines 7..2 |
| sw_pend | input | 2 | Pending software bits 1..0 |
| eic_cap | input | 1 | External controller capability flag |
| vec_mode | input | 1 | Vectored interrupt mode bit |
| vec_space | input | 5 | Vector spacing; zero means no vectoring |
| eic_level | input | 6 | Request code presented by the external controller |
| exl | input | 1 | Exception level active |
| erl | input | 1 | Error level active |
| glob_ie | input | 1 | Global interrupt enable |
| irq_req | output | 1 | Registered interrupt request |

## Verification
The classic mode is driven with single matched and mismatched line/enable pairs at both ends of the line range. This shows that each enable bit gates only its own line. For each mode-select input in turn, the other two are set to pass and that one is set to fail. The chosen stimulus gives different answers in the two modes, so a wrong mode decision changes the result. Priority codes are tried just above, equal to and just below the current level, and also at 0 and at the top level. This separates a strict comparison from a greater-or-equal one and shows that code 0 is never accepted. Software bits, hardware lines and the veto inputs are each applied against an otherwise firing setup, so that each one alone decides the output.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;

    // Total interrupt lines seen by the gate, and how many are software lines.
    parameter int NUM_LINES = 8;
    parameter int SW_LINES  = 2;
    parameter int VS_W      = 5;

    localparam int HW_LINES = NUM_LINES - SW_LINES;
    localparam int LVL_W    = HW_LINES;

    typedef logic [LVL_W-1:0]     level_t;
    typedef logic [NUM_LINES-1:0] lines_t;

    typedef enum logic {
        MODE_CLASSIC = 1'b0,
        MODE_EXTCTL = 1'b1
    } gate_mode_e;

    typedef struct packed {
        logic cls_hit;
        logic sw_hit;
        logic ext_hit;
    } hit_set_t;

    // Strict priority rule. A code of zero never wins, because no unsigned
    // level lies below zero.
    function automatic logic level_wins(level_t presented, level_t current);
        return presented > current;
    endfunction

endpackage

// File: rtl/irq_mode_detect.sv
module irq_mode_detect
    import irq_gate_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            cap,
    input  logic            vmode,
    input  logic [VS_W-1:0] spacing,
    output gate_mode_e      mode
);

    logic spacing_nz;

    always_comb begin
        spacing_nz = |spacing;
        mode = (cap && vmode && spacing_nz) ? MODE_EXTCTL : MODE_CLASSIC;
    end

    // R3: a zero spacing keeps the gate in the classic mode
    p_zero_space_classic_r3: assert property (@(posedge clk) disable iff (rst)
        (spacing == '0) |-> (mode == MODE_CLASSIC));

    // R3: without the capability flag the gate stays classic
    p_no_cap_classic_r3: assert property (@(posedge clk) disable iff (rst)
        !cap |-> (mode == MODE_CLASSIC));

endmodule

// File: rtl/irq_bit_mask.sv
module irq_bit_mask #(
    parameter int W = 8
) (
    input  logic [W-1:0] lines,
    input  logic [W-1:0] enables,
    output logic         hit
);

    logic [W-1:0] gated;

    genvar gi;
    generate
        for (gi = 0; gi < W; gi++) begin : g_bit
            assign gated[gi] = lines[gi] & enables[gi];
        end
    endgenerate

    assign hit = |gated;

endmodule

// File: rtl/irq_level_cmp.sv
module irq_level_cmp
    import irq_gate_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  level_t presented,
    input  level_t current,
    output logic   hit
);

    assign hit = level_wins(presented, current);

    // R4: an equal level must be rejected
    p_equal_rejected_r4: assert property (@(posedge clk) disable iff (rst)
        (presented == current) |-> !hit);

    // R5: code zero never passes
    p_zero_code_r5: assert property (@(posedge clk) disable iff (rst)
        (presented == '0) |-> !hit);

    // R4: the top level can never be exceeded
    p_top_level_r4: assert property (@(posedge clk) disable iff (rst)
        (current == '1) |-> !hit);

endmodule

// File: rtl/irq_gate_top.sv
module irq_gate_top
    import irq_gate_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [7:0]          irq_mask,
    input  logic [5:0]          hw_pend,
    input  logic [1:0]          sw_pend,
    input  logic                eic_cap,
    input  logic                vec_mode,
    input  logic [4:0]          vec_space,
    input  logic [5:0]          eic_level,
    input  logic                exl,
    input  logic                erl,
    input  logic                glob_ie,
    output logic                irq_req
);

    gate_mode_e mode;
    hit_set_t   hits;
    lines_t     all_lines;
    level_t     cur_level;
    logic       allow;
    logic       req_d;

    assign all_lines = {hw_pend, sw_pend};
    assign cur_level = irq_mask[NUM_LINES-1:SW_LINES];

    irq_mode_detect u_mode (
        .clk     (clk),
        .rst     (rst),
        .cap     (eic_cap),
        .vmode   (vec_mode),
        .spacing (vec_space),
        .mode    (mode)
    );

    irq_bit_mask #(.W(NUM_LINES)) u_cls (
        .lines   (all_lines),
        .enables (irq_mask),
        .hit     (hits.cls_hit)
    );

    irq_bit_mask #(.W(SW_LINES)) u_sw (
        .lines   (sw_pend),
        .enables (irq_mask[SW_LINES-1:0]),
        .hit     (hits.sw_hit)
    );

    irq_level_cmp u_cmp (
        .clk       (clk),
        .rst       (rst),
        .presented (eic_level),
        .current   (cur_level),
        .hit       (hits.ext_hit)
    );

    always_comb begin
        allow = glob_ie && !exl && !erl;
        unique case (mode)
            MODE_EXTCTL:  req_d = allow && (hits.sw_hit || hits.ext_hit);
            default:      req_d = allow && hits.cls_hit;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) irq_req <= 1'b0;
        else     irq_req <= req_d;
    end

    // R1: reset clears the request
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> !irq_req);

    // R8: exception or error level vetoes the request
    p_level_veto_r8: assert property (@(posedge clk) disable iff (rst)
        (exl || erl) |=> !irq_req);

    // R9: the global enable must be set
    p_global_en_r9: assert property (@(posedge clk) disable iff (rst)
        !glob_ie |=> !irq_req);

    // R6: an enabled pending software bit always fires when allowed
    p_sw_fires_r6: assert property (@(posedge clk) disable iff (rst)
        (glob_ie && !exl && !erl && |(sw_pend & irq_mask[1:0])) |=> irq_req);

endmodule

// File: tb/irq_gate_top_bench.sv
module irq_gate_top_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] irq_mask = '0;
    logic [5:0] hw_pend = '0;
    logic [1:0] sw_pend = '0;
    logic       eic_cap = 1'b0;
    logic       vec_mode = 1'b0;
    logic [4:0] vec_space = '0;
    logic [5:0] eic_level = '0;
    logic       exl = 1'b0;
    logic       erl = 1'b0;
    logic       glob_ie = 1'b0;
    logic       irq_req;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    typedef struct {
        logic  exp;
        string tag;
    } sb_item_t;

    sb_item_t sbq[$];

    always #10 clk = ~clk;  // 50 MHz

    irq_gate_top u_irq_gate_top (
        .clk(clk), .rst(rst), .irq_mask(irq_mask), .hw_pend(hw_pend),
        .sw_pend(sw_pend), .eic_cap(eic_cap), .vec_mode(vec_mode),
        .vec_space(vec_space), .eic_level(eic_level), .exl(exl), .erl(erl),
        .glob_ie(glob_ie), .irq_req(irq_req)
    );

    // Driver: apply one input set at a falling edge, queue the expectation.
    task automatic drive(input logic r, input logic [7:0] m, input logic [5:0] hw,
                         input logic [1:0] sw, input logic cap, input logic vm,
                         input logic [4:0] vs, input logic [5:0] lvl,
                         input logic ex, input logic er, input logic ie,
                         input logic exp, input string tag);
        sb_item_t it;
        @(negedge clk);
        rst = r; irq_mask = m; hw_pend = hw; sw_pend = sw;
        eic_cap = cap; vec_mode = vm; vec_space = vs; eic_level = lvl;
        exl = ex; erl = er; glob_ie = ie;
        it.exp = exp; it.tag = tag;
        sbq.push_back(it);
    endtask

    // Monitor: the register updates at the rising edge after the drive.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sbq.size() > 0) begin
                sb_item_t it;
                it = sbq.pop_front();
                checks++;
                if (irq_req !== it.exp) begin
                    fails++;
                    $display("FAIL %s: irq_req=%b expected=%b", it.tag, irq_req, it.exp);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: finished=0 expected=1");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        // R1: reset with a firing classic setup
        drive(1, 8'hFF, 6'h3F, 2'b11, 0, 0, 0, 0, 0, 0, 1, 0, "R1 reset");
        // R2: classic masking per bit
        drive(0, 8'h04, 6'b000001, 2'b00, 0, 0, 0, 0, 0, 0, 1, 1, "R2 line2 enabled");
        drive(0, 8'h08, 6'b000001, 2'b00, 0, 0, 0, 0, 0, 0, 1, 0, "R2 line2 wrong enable");
        drive(0, 8'h80, 6'b100000, 2'b00, 0, 0, 0, 0, 0, 0, 1, 1, "R2 line7 enabled");
        drive(0, 8'h7F, 6'b100000, 2'b00, 0, 0, 0, 0, 0, 0, 1, 0, "R2 line7 masked");
        // R6: software bits, classic
        drive(0, 8'h01, 6'h00, 2'b01, 0, 0, 0, 0, 0, 0, 1, 1, "R6 sw0 classic");
        drive(0, 8'h02, 6'h00, 2'b01, 0, 0, 0, 0, 0, 0, 1, 0, "R6 sw0 masked classic");
        // R3: each select input missing -> classic (line2 fires, level 0 would not)
        drive(0, 8'h04, 6'b000001, 2'b00, 1, 1, 0, 0, 0, 0, 1, 1, "R3 zero spacing");
        drive(0, 8'h04, 6'b000001, 2'b00, 0, 1, 1, 0, 0, 0, 1, 1, "R3 no capability");
        drive(0, 8'h04, 6'b000001, 2'b00, 1, 0, 1, 0, 0, 0, 1, 1, "R3 no vector mode");
        drive(0, 8'h04, 6'b000001, 2'b00, 1, 1, 1, 0, 0, 0, 1, 0, "R3 all set -> ext mode");
        // R4: strict comparison, current level 10
        drive(0, 8'h28, 6'h00, 2'b00, 1, 1, 1, 6'd11, 0, 0, 1, 1, "R4 above level");
        drive(0, 8'h28, 6'h00, 2'b00, 1, 1, 1, 6'd10, 0, 0, 1, 0, "R4 equal level");
        drive(0, 8'h28, 6'h00, 2'b00, 1, 1, 1, 6'd9,  0, 0, 1, 0, "R4 below level");
        drive(0, 8'hFC, 6'h00, 2'b00, 1, 1, 4, 6'd63, 0, 0, 1, 0, "R4 top level equal");
        // R5: zero code
        drive(0, 8'h00, 6'h00, 2'b00, 1, 1, 1, 6'd0, 0, 0, 1, 0, "R5 zero code");
        drive(0, 8'h00, 6'h00, 2'b00, 1, 1, 1, 6'd1, 0, 0, 1, 1, "R5 code one");
        // R6: software bits in ext mode ignore the level
        drive(0, 8'hFD, 6'h00, 2'b01, 1, 1, 1, 6'd0, 0, 0, 1, 1, "R6 sw0 ext mode");
        drive(0, 8'hFD, 6'h00, 2'b10, 1, 1, 1, 6'd0, 0, 0, 1, 0, "R6 sw1 masked ext mode");
        // R7: hardware lines ignored in ext mode
        drive(0, 8'hFC, 6'h3F, 2'b00, 1, 1, 1, 6'd0, 0, 0, 1, 0, "R7 hw ignored");
        // R8: vetoes
        drive(0, 8'hFF, 6'h3F, 2'b11, 0, 0, 0, 0, 1, 0, 1, 0, "R8 exl classic");
        drive(0, 8'hFF, 6'h3F, 2'b11, 0, 0, 0, 0, 0, 1, 1, 0, "R8 erl classic");
        drive(0, 8'h00, 6'h00, 2'b00, 1, 1, 1, 6'd5, 1, 0, 1, 0, "R8 exl ext mode");
        // R9: global enable
        drive(0, 8'hFF, 6'h3F, 2'b11, 0, 0, 0, 0, 0, 0, 0, 0, "R9 global disable");
        // R10: rise then fall, one edge each
        drive(0, 8'h40, 6'b010000, 2'b00, 0, 0, 0, 0, 0, 0, 1, 1, "R10 rises");
        drive(0, 8'h40, 6'b000000, 2'b00, 0, 0, 0, 0, 0, 0, 1, 0, "R10 falls");
        drive(0, 8'h40, 6'b010000, 2'b00, 0, 0, 0, 0, 0, 0, 1, 1, "R10 rises again");
        wait (sbq.size() == 0);
        @(posedge clk);
        #2;
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule